// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block accepts 24-bit configuration words from an external controller over three lines: a serial clock, a serial data line and a load strobe. All three lines are brought into the system clock domain through two-flop synchronizers, and edges are found on the synchronized levels. Each rising edge of the serial clock seen while the load strobe is low appends one data bit to a shift register, most significant bit first.

A rising edge of the load strobe copies the shift register into one of three parallel configuration registers: control, reference divider or feedback divider. The two bits at the tail of the word, bits 1 and 0, select the register. The written register raises a one-cycle update pulse, and the other registers hold their values. A guard measures serial clock high and low times, the spacing from the last serial clock rise to the load strobe, and the load strobe width, all in system clock cycles. It pulses an error output when any of them is too short.

Top module: `serial_cfg_loader`

## Requirements
- R1: A word is shifted in most significant bit first: after any number of serial clock rising edges with the load strobe low, register bit 0 holds the last bit received and bit 23 holds the bit received 23 rising edges earlier.
- R2: On a load strobe rise, the shifted word's bits [1:0] pick the destination: 2'b00 the control register, 2'b01 the reference-divider register, 2'b10 the feedback-divider register. 2'b11 writes nothing and raises no update pulse.
- R3: The whole 24-bit shifted word, control bits included, is copied into the destination register only on a load strobe rising edge. A bit count never triggers a transfer.
- R4: Exactly one update pulse, lasting one system clock cycle, goes with each write, and only on the written register. Registers that are not written keep their contents.
- R5: Serial clock rising edges that occur while the load strobe is high do not change the shift register.
- R6: The destination register and its update pulse change on the third system clock rising edge after the load strobe input goes high.
- R7: After reset, all three registers are zero and the update pulses and the error output are low.
- R8: A serial clock high phase shorter than MIN_HI_CYC cycles, or a low phase shorter than MIN_LO_CYC cycles, raises a one-cycle timing error pulse.
- R9: A load strobe rise less than MIN_GAP_CYC cycles after the last serial clock rise raises a one-cycle timing error pulse. The transfer still takes place.
- R10: A load strobe pulse shorter than MIN_LE_CYC cycles raises a one-cycle timing error pulse when it falls. The transfer still takes place.
- R11: When more than 24 bits are shifted before a load strobe, only the last 24 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sle_i | input | 1 | Load strobe, asynchronous |
| ctrl_word_o | output | 24 | Control register |
| ctrl_stb_o | output | 1 | Control register update pulse |
| ref_word_o | output | 24 | Reference-divider register |
| ref_stb_o | output | 1 | Reference-divider update pulse |
| fb_word_o | output | 24 | Feedback-divider register |
| fb_stb_o | output | 1 | Feedback-divider update pulse |
| timing_err_o | output | 1 | One-cycle pulse on a serial timing violation |

## Verification
Words with all-ones, alternating and random payloads are sent to each destination code. This shows whether routing depends only on the tail bits and whether bit order is preserved. A 30-bit burst separates keeping the last 24 bits from keeping the first 24. Serial clock pulses sent while the load strobe is high, followed by a strobe with no new bits, show whether the shift register was frozen. Short high, short low, late-gap and narrow-strobe cases are each sent once alone, so every error pulse can be traced to one rule, while random legal timing must never raise the error.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_REF  = 2'b01,
    SEL_FB   = 2'b10,
    SEL_NONE = 2'b11
  } cfg_sel_e;

  localparam int unsigned CFG_WORD_W = 24;
  localparam int unsigned CFG_SEL_W  = 2;
  localparam int unsigned CFG_N_LAT  = 3;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_shift_core.sv
module cfg_shift_core #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
  end

  assert_msb_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (word_o[0] == $past(bit_i)) && (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import serial_cfg_pkg::*;
#(
  parameter int unsigned WORD_W = CFG_WORD_W,
  parameter int unsigned SEL_W  = CFG_SEL_W,
  parameter int unsigned N_LAT  = CFG_N_LAT
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [WORD_W-1:0]              word_i,
  output logic [N_LAT-1:0][WORD_W-1:0]   lat_o,
  output logic [N_LAT-1:0]               stb_o
);
  logic [SEL_W-1:0] sel;
  assign sel = word_i[SEL_W-1:0];

  for (genvar g = 0; g < N_LAT; g++) begin : g_lat
    logic wr;
    assign wr = load_i && (sel == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_o[g] <= '0;
        stb_o[g] <= 1'b0;
      end else begin
        stb_o[g] <= wr;
        if (wr) lat_o[g] <= word_i;
      end
    end

    assert_keep_unwritten_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_o[g] |-> $stable(lat_o[g]));
  end

  assert_single_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
  assert_code3_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel == SEL_W'(SEL_NONE)) |=> (stb_o == '0));
  assert_strobe_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o != '0) |=> (stb_o == '0));
endmodule

// File: rtl/cfg_timing_guard.sv
module cfg_timing_guard #(
  parameter int unsigned MIN_HI_CYC  = 3,
  parameter int unsigned MIN_LO_CYC  = 3,
  parameter int unsigned MIN_GAP_CYC = 6,
  parameter int unsigned MIN_LE_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_lvl_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  input  logic le_lvl_i,
  input  logic le_rise_i,
  input  logic le_fall_i,
  output logic err_o
);
  localparam int unsigned MAX_A   = (MIN_HI_CYC > MIN_LO_CYC) ? MIN_HI_CYC : MIN_LO_CYC;
  localparam int unsigned MAX_B   = (MIN_GAP_CYC > MIN_LE_CYC) ? MIN_GAP_CYC : MIN_LE_CYC;
  localparam int unsigned CNT_TOP = ((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(CNT_TOP);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(MIN_HI_CYC);
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(MIN_LO_CYC);
  localparam logic [CNT_W-1:0] LIM_GP = CNT_W'(MIN_GAP_CYC);
  localparam logic [CNT_W-1:0] LIM_LE = CNT_W'(MIN_LE_CYC);

  logic [CNT_W-1:0] hi_q, lo_q, gap_q, le_q;
  logic             viol;

  // measured length includes the edge cycle itself
  function automatic logic [CNT_W-1:0] step(logic start, logic run, logic [CNT_W-1:0] cur);
    if (start)                   return CNT_W'(1);
    else if (run && cur != SAT)  return cur + 1'b1;
    else                         return cur;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= SAT;
      lo_q  <= SAT;
      gap_q <= SAT;
      le_q  <= SAT;
    end else begin
      hi_q  <= step(sclk_rise_i, sclk_lvl_i, hi_q);
      lo_q  <= step(sclk_fall_i, !sclk_lvl_i, lo_q);
      gap_q <= step(sclk_rise_i, 1'b1, gap_q);
      le_q  <= step(le_rise_i, le_lvl_i, le_q);
    end
  end

  assign viol = (sclk_fall_i && hi_q  < LIM_HI) ||
                (sclk_rise_i && lo_q  < LIM_LO) ||
                (le_rise_i   && gap_q < LIM_GP) ||
                (le_fall_i   && le_q  < LIM_LE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= viol;
  end

  assert_err_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(sclk_rise_i || sclk_fall_i || le_rise_i || le_fall_i));
  assert_gap_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise_i && !sclk_rise_i && !sclk_fall_i && gap_q >= LIM_GP) |=> !err_o);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int unsigned WORD_W      = CFG_WORD_W,
  parameter int unsigned MIN_HI_CYC  = 3,
  parameter int unsigned MIN_LO_CYC  = 3,
  parameter int unsigned MIN_GAP_CYC = 6,
  parameter int unsigned MIN_LE_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sle_i,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic              ctrl_stb_o,
  output logic [WORD_W-1:0] ref_word_o,
  output logic              ref_stb_o,
  output logic [WORD_W-1:0] fb_word_o,
  output logic              fb_stb_o,
  output logic              timing_err_o
);
  localparam int unsigned N_LINES = 3;
  localparam int unsigned IX_SCLK = 0;
  localparam int unsigned IX_DATA = 1;
  localparam int unsigned IX_LE   = 2;

  logic [N_LINES-1:0]                  sync;
  logic                                sclk_prev_q, le_prev_q;
  logic                                sclk_rise, sclk_fall, le_rise, le_fall;
  logic [WORD_W-1:0]                   shift_word;
  logic [CFG_N_LAT-1:0][WORD_W-1:0]    lat;
  logic [CFG_N_LAT-1:0]                stb;

  cfg_sync #(.W(N_LINES), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sle_i, sdata_i, sclk_i}),
    .sync_o  (sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b0;
    end else begin
      sclk_prev_q <= sync[IX_SCLK];
      le_prev_q   <= sync[IX_LE];
    end
  end

  assign sclk_rise =  sync[IX_SCLK] && !sclk_prev_q;
  assign sclk_fall = !sync[IX_SCLK] &&  sclk_prev_q;
  assign le_rise   =  sync[IX_LE]   && !le_prev_q;
  assign le_fall   = !sync[IX_LE]   &&  le_prev_q;

  cfg_shift_core #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_rise && !sync[IX_LE]),
    .bit_i   (sync[IX_DATA]),
    .word_o  (shift_word)
  );

  cfg_latch_bank #(.WORD_W(WORD_W), .SEL_W(CFG_SEL_W), .N_LAT(CFG_N_LAT)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (le_rise),
    .word_i (shift_word),
    .lat_o  (lat),
    .stb_o  (stb)
  );

  cfg_timing_guard #(
    .MIN_HI_CYC (MIN_HI_CYC),
    .MIN_LO_CYC (MIN_LO_CYC),
    .MIN_GAP_CYC(MIN_GAP_CYC),
    .MIN_LE_CYC (MIN_LE_CYC)
  ) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_lvl_i  (sync[IX_SCLK]),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .le_lvl_i    (sync[IX_LE]),
    .le_rise_i   (le_rise),
    .le_fall_i   (le_fall),
    .err_o       (timing_err_o)
  );

  assign ctrl_word_o = lat[SEL_CTRL];
  assign ref_word_o  = lat[SEL_REF];
  assign fb_word_o   = lat[SEL_FB];
  assign ctrl_stb_o  = stb[SEL_CTRL];
  assign ref_stb_o   = stb[SEL_REF];
  assign fb_stb_o    = stb[SEL_FB];

  assert_xfer_on_le_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_stb_o || ref_stb_o || fb_stb_o) |-> $past(le_rise));
  assert_frozen_le_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync[IX_LE] |=> $stable(shift_word));
endmodule

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [23:0] ctrl_w, ref_w, fb_w;
  logic ctrl_s, ref_s, fb_s, terr;

  always #2.5 clk = ~clk;

  serial_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .ctrl_word_o(ctrl_w), .ctrl_stb_o(ctrl_s), .ref_word_o(ref_w), .ref_stb_o(ref_s),
    .fb_word_o(fb_w), .fb_stb_o(fb_s), .timing_err_o(terr)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_stb = 0, last_cyc = 0, n_err = 0, err_exp = 0;
  logic [2:0] last_vec = '0;
  logic [23:0] m_sr = '0;
  logic [23:0] m_lat [3];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_ni) begin
    if (ctrl_s || ref_s || fb_s) begin
      n_stb    <= n_stb + 1;
      last_cyc <= cyc;
      last_vec <= {fb_s, ref_s, ctrl_s};
    end
    if (terr) n_err <= n_err + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // entry and exit at a negedge
  task automatic shift_bits(input logic [31:0] w, input int n, input int hi, input int lo,
                            input int bad_hi, input int bad_lo);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      sdata = w[i];
      repeat ((i == bad_lo) ? 2 : lo) @(negedge clk);
      sclk = 1'b1;
      if (!sle) m_sr = {m_sr[22:0], w[i]};
      repeat ((i == bad_hi) ? 2 : hi) @(negedge clk);
    end
    sclk = 1'b0;
  endtask

  task automatic le_pulse(input int gap, input int wid, input string req);
    int c0, s0;
    logic [1:0] code;
    repeat (gap) @(negedge clk);
    s0 = n_stb;
    c0 = cyc;
    code = m_sr[1:0];
    sle = 1'b1;
    repeat (wid) @(negedge clk);
    sle = 1'b0;
    repeat (8) @(negedge clk);
    if (code != 2'b11) m_lat[code] = m_sr;
    chk(n_stb - s0 == ((code == 2'b11) ? 0 : 1), {req, " R4 strobe count"}, n_stb - s0, (code == 2'b11) ? 0 : 1);
    if (code != 2'b11) begin
      chk(last_cyc == c0 + 3, {req, " R6 latency"}, last_cyc - c0, 3);
      chk(last_vec == 3'(1 << code), {req, " R2 routing"}, last_vec, 3'(1 << code));
    end
    chk(ctrl_w == m_lat[0], {req, " R3 ctrl word"}, ctrl_w, m_lat[0]);
    chk(ref_w  == m_lat[1], {req, " R3 ref word"},  ref_w,  m_lat[1]);
    chk(fb_w   == m_lat[2], {req, " R3 fb word"},   fb_w,   m_lat[2]);
    chk(n_err == err_exp, {req, " timing err count"}, n_err, err_exp);
  endtask

  task automatic send(input logic [23:0] w, input string req);
    shift_bits({8'h0, w}, 24, 4, 4, -1, -1);
    le_pulse(4, 5, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int k = 0; k < 3; k++) m_lat[k] = '0;
    repeat (4) @(negedge clk);
    chk(ctrl_w == 0 && ref_w == 0 && fb_w == 0, "R7 reset words", {ctrl_w[7:0], ref_w[7:0], fb_w[7:0]}, 0);
    chk({ctrl_s, ref_s, fb_s, terr} == 0, "R7 reset strobes", {ctrl_s, ref_s, fb_s, terr}, 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);

    send(24'hFFFFFC, "R2 ctrl ones");
    send(24'hA5A5A5 & 24'hFFFFFD | 24'h1, "R2 ref alt");
    send(24'h123456 & 24'hFFFFFE | 24'h2, "R2 fb");
    send(24'h5A5A5B, "R2 code11 ignored");
    // R11: 30 bits, last 24 kept
    shift_bits(32'h3C0F0F0E, 30, 4, 4, -1, -1);
    le_pulse(4, 5, "R11 long word");
    chk(fb_w == 24'h0F0F0E, "R11 last 24 bits", fb_w, 24'h0F0F0E);
    // R1 bit order
    send(24'h800001, "R1 msb first");
    chk(ref_w == 24'h800001, "R1 ref value", ref_w, 24'h800001);

    // R5: clock pulses during strobe high are ignored
    send(24'hC33301, "R5 setup");
    sle = 1'b1;
    repeat (6) @(negedge clk);
    shift_bits(32'hFF, 8, 4, 4, -1, -1);
    repeat (4) @(negedge clk);
    sle = 1'b0;
    repeat (8) @(negedge clk);
    le_pulse(6, 5, "R5 reload");
    chk(ref_w == 24'hC33301, "R5 shift frozen", ref_w, 24'hC33301);

    // R8 short high
    shift_bits(32'h00ABCD00, 24, 4, 4, 7, -1);
    err_exp++;
    le_pulse(4, 5, "R8 short high");
    // R8 short low
    shift_bits(32'h00ABCD01, 24, 4, 4, -1, 12);
    err_exp++;
    le_pulse(4, 5, "R8 short low");
    // R9 late gap: 4 + 1 < 6
    shift_bits(32'h00777702, 24, 4, 4, -1, -1);
    err_exp++;
    le_pulse(1, 5, "R9 short gap");
    // R10 narrow strobe
    shift_bits(32'h00999900, 24, 4, 4, -1, -1);
    err_exp++;
    le_pulse(4, 2, "R10 narrow strobe");

    for (int t = 0; t < 40; t++) begin
      logic [23:0] w;
      w = 24'($urandom);
      shift_bits({8'h0, w}, 24, 3 + int'($urandom % 4), 3 + int'($urandom % 4), -1, -1);
      le_pulse(3 + int'($urandom % 3), 4 + int'($urandom % 4), "R2 R3 random");
    end
    summary();
  end
endmodule